// File: doc/BRIEF.md
# Edge-Counting Subcarrier Bit Receiver

This block decodes a reply from a contactless tag that carries no start marker, stop marker or length field. Its only signal input is one digital line from a hysteresis comparator. While the tag sends a 1 the line toggles at the subcarrier rate, and while it sends a 0 the line stays quiet. The controller pulses `start_i` at the moment the reader frame ends, which is the timing reference. The block then waits a fixed turnaround, divides the following time into equal bit windows and counts the level changes in each window. A count that falls inside an accept band gives a 1. Any other count gives a 0.

The caller states how many bits to expect, and the block limits that number to its maximum. If decryption is requested, the block first steps an external keystream source. It discards a fixed number of keystream outputs and then stores one output per expected bit, all before the first window opens. Each decoded 1 then inverts the stored bit at the same position. The block reports the received word, the bit count and a one-cycle valid strobe. Because a silent line decodes as all zeros, a reply of all 0 bits cannot be told apart from no tag at all.

Top module: `edge_bit_rx`

## Requirements
- R1: After reset `valid_o` is 0, `data_o` is 0, `bits_o` is 0 and `ks_step_o` is 0.
- R2: The first bit window opens WAIT_TICKS ticks (one tick is TICK_DIV clock cycles) after the cycle that accepts `start_i`. Level changes before that moment do not count toward any bit.
- R3: Each bit window lasts BIT_TICKS ticks. `valid_o` rises (WAIT_TICKS + n*BIT_TICKS)*TICK_DIV cycles after `start_i` is accepted, where n is the clamped bit count. The tick counter restarts after the last window.
- R4: A window with a count strictly above LO_EDGES (20) and strictly below HI_EDGES (60) decodes as 1. Any other count, including exactly 20 or exactly 60, decodes as 0.
- R5: The per-window edge counter saturates and does not wrap, so a very large count such as 100 edges decodes as 0.
- R6: A requested count `req_bits_i` above MAX_BITS (16) is clamped to MAX_BITS, and `bits_o` reports the clamped value.
- R7: The bit from window i is placed at `data_o[i]`, so the first window is the LSB. Bits at positions `bits_o` and above are 0.
- R8: With `crypt_i` = 1, `ks_step_o` is high for exactly KS_SKIP+n consecutive cycles right after start. The first KS_SKIP values of `ks_bit_i` are discarded, and the value seen in the following cycles forms mask bit 0, 1, and so on. The output bit i is mask[i] XOR decoded bit i.
- R9: With `crypt_i` = 0, `ks_step_o` never rises and the output is the plain decoded bits.
- R10: `valid_o` is high for one cycle only. `data_o` and `bits_o` hold their values until the next frame completes.
- R11: A `start_i` pulse that arrives while a frame is in progress is ignored.
- R12: A silent line decodes as all-zero data with the full bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse at the end of the reader frame (timing reference) |
| req_bits_i | input | 5 | Number of bits to receive, before clamping |
| crypt_i | input | 1 | Apply the keystream mask to the decoded bits |
| rx_i | input | 1 | Comparator line (asynchronous) |
| ks_bit_i | input | 1 | Current output of the external keystream source |
| ks_step_o | output | 1 | Advance the keystream source by one step |
| data_o | output | 16 | Received word, LSB first |
| bits_o | output | 5 | Number of bits in `data_o` |
| valid_o | output | 1 | One-cycle strobe when a frame is complete |

## Verification
The hardest conditions to reach are the ones on the edges of the decision: window counts of exactly 20, 21, 59 and 60, and a count large enough that a wrapping counter would land back inside the accept band. The bench drives the comparator line with an exact number of toggles, two cycles apart, placed in the middle of each window. This gives an exact count for every window. A burst of toggles placed just before the turnaround ends checks that activity ahead of the first window is discarded. A second start pulse during the wait checks that a frame in progress is not disturbed.

// File: rtl/edge_bit_rx_pkg.sv
package edge_bit_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_KEYS = 2'd1,
        ST_WAIT = 2'd2,
        ST_RECV = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = run && (pre_q == PW'(DIV - 1));
        pre_d = pre_q;
        if (restart || !run || tick) begin
            pre_d = '0;
        end else begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/rx_sync_edge.sv
module rx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], line_i};
        edge_o  = chain_q[STAGES] ^ chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end
endmodule

// File: rtl/rx_edge_count.sv
module rx_edge_count #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             edge_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (edge_i && (cnt_q != {CNT_W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
        cnt_o = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/edge_bit_rx.sv
module edge_bit_rx
    import edge_bit_rx_pkg::*;
#(
    parameter int TICK_DIV   = 32,
    parameter int WAIT_TICKS = 490,
    parameter int BIT_TICKS  = 150,
    parameter int LO_EDGES   = 20,
    parameter int HI_EDGES   = 60,
    parameter int MAX_BITS   = 16,
    parameter int REQ_W      = 5,
    parameter int KS_SKIP    = 2,
    parameter int SYNC_STG   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic [REQ_W-1:0]             req_bits_i,
    input  logic                         crypt_i,
    input  logic                         rx_i,
    input  logic                         ks_bit_i,
    output logic                         ks_step_o,
    output logic [MAX_BITS-1:0]          data_o,
    output logic [$clog2(MAX_BITS+1)-1:0] bits_o,
    output logic                         valid_o
);
    localparam int NB_W   = $clog2(MAX_BITS + 1);
    localparam int IX_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
    localparam int KC_W   = $clog2(KS_SKIP + MAX_BITS + 1);
    localparam int MAXT   = (WAIT_TICKS > BIT_TICKS) ? WAIT_TICKS : BIT_TICKS;
    localparam int TICK_W = $clog2(MAXT + 1);
    localparam int CNT_W  = $clog2(HI_EDGES + 1);

    typedef struct packed {
        rx_state_e           state;
        logic [TICK_W-1:0]   ticks;
        logic [NB_W-1:0]     nbits;
        logic [NB_W-1:0]     idx;
        logic [KC_W-1:0]     kcnt;
        logic [MAX_BITS-1:0] mask;
        logic [MAX_BITS-1:0] acc;
        logic [MAX_BITS-1:0] data;
        logic [NB_W-1:0]     bits;
        logic                valid;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic             tick, restart, run, clr, edge_s, hit;
    logic [CNT_W-1:0] cnt;
    logic [KC_W-1:0]  kpos;
    logic [MAX_BITS-1:0] acc_n;

    rx_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(run), .tick(tick)
    );

    rx_sync_edge #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(rx_i), .edge_o(edge_s)
    );

    rx_edge_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .edge_i(edge_s), .cnt_o(cnt)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        ks_step_o = 1'b0;
        clr       = 1'b0;
        restart   = 1'b0;
        run       = (r_q.state != ST_IDLE);
        hit       = (cnt > CNT_W'(LO_EDGES)) && (cnt < CNT_W'(HI_EDGES));
        kpos      = r_q.kcnt - KC_W'(KS_SKIP);
        acc_n     = r_q.acc;

        if ((r_q.state == ST_KEYS) || (r_q.state == ST_WAIT)) begin
            if (tick) r_d.ticks = r_q.ticks + 1'b1;
        end

        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.nbits = (req_bits_i > REQ_W'(MAX_BITS)) ? NB_W'(MAX_BITS)
                                                                : NB_W'(req_bits_i);
                    r_d.acc   = '0;
                    r_d.mask  = '0;
                    r_d.idx   = '0;
                    r_d.kcnt  = '0;
                    r_d.ticks = '0;
                    restart   = 1'b1;
                    clr       = 1'b1;
                    r_d.state = crypt_i ? ST_KEYS : ST_WAIT;
                end
            end
            ST_KEYS: begin
                ks_step_o = 1'b1;
                if (r_q.kcnt >= KC_W'(KS_SKIP)) begin
                    r_d.mask[kpos[IX_W-1:0]] = ks_bit_i;
                end
                r_d.kcnt = r_q.kcnt + 1'b1;
                if ((r_q.kcnt + 1'b1) >= (KC_W'(KS_SKIP) + KC_W'(r_q.nbits))) begin
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tick && (r_q.ticks == TICK_W'(WAIT_TICKS - 1))) begin
                    r_d.ticks = '0;
                    clr       = 1'b1;
                    if (r_q.nbits == '0) begin
                        r_d.data  = '0;
                        r_d.bits  = '0;
                        r_d.valid = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_RECV;
                    end
                end
            end
            ST_RECV: begin
                if (tick) begin
                    r_d.ticks = r_q.ticks + 1'b1;
                    if (r_q.ticks == TICK_W'(BIT_TICKS - 1)) begin
                        r_d.ticks = '0;
                        clr       = 1'b1;
                        acc_n[r_q.idx[IX_W-1:0]] = r_q.mask[r_q.idx[IX_W-1:0]] ^ hit;
                        r_d.acc   = acc_n;
                        r_d.idx   = r_q.idx + 1'b1;
                        if (r_q.idx == (r_q.nbits - 1'b1)) begin
                            r_d.data  = acc_n;
                            r_d.bits  = r_q.nbits;
                            r_d.valid = 1'b1;
                            r_d.state = ST_IDLE;
                        end
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        data_o  = r_q.data;
        bits_o  = r_q.bits;
        valid_o = r_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/edge_bit_rx_checker.sv
module edge_bit_rx_checker #(
    parameter int MAX_BITS = 16,
    parameter int NB_W     = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_o,
    input logic                ks_step_o,
    input logic [MAX_BITS-1:0] data_o,
    input logic [NB_W-1:0]     bits_o
);
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_hold_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(data_o) && $stable(bits_o)));

    p_count_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bits_o <= NB_W'(MAX_BITS));

    p_upper_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((data_o >> bits_o) == '0));

    p_no_step_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !ks_step_o);
endmodule

bind edge_bit_rx edge_bit_rx_checker #(
    .MAX_BITS(MAX_BITS),
    .NB_W($clog2(MAX_BITS + 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_o(valid_o), .ks_step_o(ks_step_o),
    .data_o(data_o), .bits_o(bits_o)
);

// File: tb/edge_bit_rx_test.sv
module edge_bit_rx_test;
    localparam int DIV  = 2;
    localparam int WT   = 490;
    localparam int BT   = 150;
    localparam int BASE = WT * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  req_bits_i = '0;
    logic        crypt_i = 1'b0;
    logic        rx_i = 1'b0;
    logic        ks_bit_i;
    logic        ks_step_o;
    logic [15:0] data_o;
    logic [4:0]  bits_o;
    logic        valid_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int start_cyc = 0;
    int steps = 0;
    int vcount = 0;
    int cnts[16];
    logic [15:0] ks_st = 16'hACE1;
    logic [15:0] exp_d[$];
    int exp_b[$];
    int exp_lat[$];
    string exp_tag[$];

    always #2.5 clk = ~clk;

    edge_bit_rx #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_bits_i(req_bits_i),
        .crypt_i(crypt_i), .rx_i(rx_i), .ks_bit_i(ks_bit_i), .ks_step_o(ks_step_o),
        .data_o(data_o), .bits_o(bits_o), .valid_o(valid_o)
    );

    assign ks_bit_i = ks_st[0];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ks_step_o) begin
            ks_st <= {ks_st[0] ^ ks_st[2] ^ ks_st[3] ^ ks_st[5], ks_st[15:1]};
            steps <= steps + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] ks_next(input logic [15:0] s);
        return {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
    endfunction

    // Monitor: pops the scoreboard whenever the design strobes a result
    initial begin
        forever begin
            @(negedge clk);
            if (valid_o) begin
                vcount++;
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R10 unexpected strobe", 1, 0);
                end else begin
                    logic [15:0] ed;
                    int eb, el;
                    string t;
                    ed = exp_d.pop_front();
                    eb = exp_b.pop_front();
                    el = exp_lat.pop_front();
                    t  = exp_tag.pop_front();
                    chk(data_o == ed, {t, " data"}, data_o, ed);
                    chk(int'(bits_o) == eb, "R6 bit count", bits_o, eb);
                    chk((cyc - start_cyc >= el - 1) && (cyc - start_cyc <= el + 2),
                        "R3 latency", cyc - start_cyc, el);
                end
            end
        end
    end

    task automatic run_frame(input int req, input bit crypt, input bit pre_edges,
                             input bit poke, input string tag);
        int n;
        logic [15:0] s, mask, ed;
        n = (req > 16) ? 16 : req;
        s = ks_st;
        mask = '0;
        if (crypt) begin
            for (int k = 0; k < 2; k++) s = ks_next(s);
            for (int i = 0; i < n; i++) begin
                mask[i] = s[0];
                s = ks_next(s);
            end
        end
        ed = mask;
        for (int i = 0; i < n; i++) begin
            if (cnts[i] > 20 && cnts[i] < 60) ed[i] = ~ed[i];
        end
        exp_d.push_back(ed);
        exp_b.push_back(n);
        exp_lat.push_back((WT + n * BT) * DIV + 1);
        exp_tag.push_back(tag);
        steps = 0;
        @(negedge clk);
        start_i = 1'b1;
        req_bits_i = 5'(req);
        crypt_i = crypt;
        start_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        if (pre_edges) begin
            repeat (BASE - 101) @(negedge clk);
            for (int k = 0; k < 40; k++) begin
                rx_i = ~rx_i;
                repeat (2) @(negedge clk);
            end
            repeat (20) @(negedge clk);
        end else if (poke) begin
            repeat (BASE / 2) @(negedge clk);
            start_i = 1'b1;
            req_bits_i = 5'd2;
            @(negedge clk);
            start_i = 1'b0;
            repeat (BASE - 2 - BASE / 2) @(negedge clk);
        end else begin
            repeat (BASE - 1) @(negedge clk);
        end
        for (int i = 0; i < n; i++) begin
            repeat (20) @(negedge clk);
            for (int k = 0; k < cnts[i]; k++) begin
                rx_i = ~rx_i;
                repeat (2) @(negedge clk);
            end
            repeat (BT * DIV - 20 - 2 * cnts[i]) @(negedge clk);
        end
        repeat (30) @(negedge clk);
        if (crypt) chk(steps == 2 + n, "R8 keystream steps", steps, 2 + n);
        else       chk(steps == 0, "R9 no keystream steps", steps, 0);
    endtask

    task automatic set_cnts(input int v);
        for (int i = 0; i < 16; i++) cnts[i] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] held;
        int vc;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
        chk(data_o == '0, "R1 data", data_o, 0);
        chk(bits_o == '0, "R1 bits", bits_o, 0);
        chk(ks_step_o == 1'b0, "R1 ks_step", ks_step_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 R7 R9: mixed pattern, plain
        set_cnts(0);
        cnts[0] = 42; cnts[2] = 42; cnts[3] = 42; cnts[6] = 42;
        run_frame(8, 1'b0, 1'b0, 1'b0, "R7 lsb-first plain");

        // R4: band limits 20,21,59,60
        set_cnts(0);
        cnts[0] = 20; cnts[1] = 21; cnts[2] = 59; cnts[3] = 60;
        run_frame(4, 1'b0, 1'b0, 1'b0, "R4 band limits");

        // R5: saturation
        set_cnts(0);
        cnts[0] = 100; cnts[1] = 42;
        run_frame(2, 1'b0, 1'b0, 1'b0, "R5 saturation");

        // R6: clamp
        set_cnts(42);
        run_frame(25, 1'b0, 1'b0, 1'b0, "R6 clamp");

        // R8: keystream mask
        set_cnts(0);
        cnts[1] = 30; cnts[4] = 42; cnts[5] = 50; cnts[9] = 42; cnts[11] = 25;
        run_frame(12, 1'b1, 1'b0, 1'b0, "R8 decrypt");

        // R2: edges before the first window are ignored
        set_cnts(0);
        cnts[1] = 42;
        run_frame(3, 1'b0, 1'b1, 1'b0, "R2 turnaround");

        // R12: silence gives zeros
        set_cnts(0);
        run_frame(16, 1'b0, 1'b0, 1'b0, "R12 silence");

        // R11: start during a frame is ignored
        set_cnts(42);
        cnts[1] = 0;
        vc = vcount;
        run_frame(5, 1'b0, 1'b0, 1'b1, "R11 busy start");
        chk(vcount == vc + 1, "R11 single result", vcount - vc, 1);

        // R10: result held, strobe gone
        held = data_o;
        repeat (50) @(negedge clk);
        chk(data_o == held, "R10 data held", data_o, held);
        chk(valid_o == 1'b0, "R10 strobe low", valid_o, 0);
        chk(exp_d.size() == 0, "R3 all results seen", exp_d.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule